// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

A four-bit synchronous counter that runs either as a modulo-16 binary counter or as a modulo-10 BCD digit, counting up or down. An active-low carry-in acts as the count enable. While the preset input is high, the four parallel load bits appear on the count outputs at once, and the stored state takes that value without a clock edge.

An active-low carry-out is driven combinationally. It goes low when the count sits at its terminal value for the current direction and mode, and only while carry-in is low. Several instances share one clock and are chained by feeding each carry-out into the next stage's carry-in. The chain then counts as one synchronous multi-digit decimal or hexadecimal number. Each stage sees its carry-in low only in the cycle where every lower stage is at its terminal value.

A preset value above 9 in decade mode is not a legal digit. The counter leaves such a value on the first count, and carry-out stays high while the value is held.

Top module: `updown_decbin_counter`

## Requirements
- R1: While `load_en` is high, `q` equals `jam` with no clock edge needed, and the stored state takes that value. A `jam` of 4'b0000 gives a count of zero.
- R2: The count does not change on a rising clock edge while `cin_n` is high or while `load_en` is high.
- R3: With `bin_sel`=1 and `up_sel`=1, each enabled rising edge adds one modulo 16, so 15 is followed by 0.
- R4: With `bin_sel`=1 and `up_sel`=0, each enabled rising edge subtracts one modulo 16, so 0 is followed by 15.
- R5: With `bin_sel`=0 and `up_sel`=1, the count steps through 0 to 9, and 9 is followed by 0.
- R6: With `bin_sel`=0 and `up_sel`=0, the count steps down, and 0 is followed by 9.
- R7: `cout_n` is low exactly when `cin_n` is low and the count is terminal: 15 (binary, up), 9 (decade, up) or 0 (down, either mode). A change on `cin_n` reaches `cout_n` without a clock edge.
- R8: In decade mode a count of 10 to 15 never drives `cout_n` low. One enabled edge takes it to 0 when counting up and to 9 when counting down.
- R9: `rst_n` low clears the count to 0 at once.
- R10: Three decade stages on one clock, each `cout_n` feeding the next stage's `cin_n`, count as a single three-digit decimal number that wraps from 999 to 000.
- R11: After `load_en` falls, the next enabled rising edge counts on from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| cin_n | input | 1 | Carry-in, active-low count enable |
| bin_sel | input | 1 | 1 = binary modulo 16, 0 = BCD modulo 10 |
| up_sel | input | 1 | 1 = count up, 0 = count down |
| load_en | input | 1 | Asynchronous preset enable, active high |
| jam | input | 4 | Parallel preset value |
| q | output | 4 | Current count |
| cout_n | output | 1 | Terminal-count carry-out, active low |

## Verification
Counting is tried from presets just below each wrap point in all four combinations of mode and direction. These runs separate a modulo-16 step from a modulo-10 step and show which terminal value each direction uses. Presets of illegal BCD codes show whether the recovery goes to 0 or to 9, and confirm that no false carry is raised. A held carry-in and a held preset show that the enable is gated and not merely sampled late. Carry-in is toggled between edges to show that the carry-out is combinational. A three-stage decade chain crossing 999 shows whether the look-ahead carry lines up with the shared clock.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;

  localparam int CNT_W   = 4;
  localparam int BIN_TOP = (1 << CNT_W) - 1;
  localparam int DEC_TOP = 9;

  typedef logic [CNT_W-1:0] cnt_t;

  // Next count for one enabled step; illegal BCD codes recover in one step.
  function automatic cnt_t step_value(input cnt_t cur, input logic up, input logic bin);
    cnt_t r;
    if (bin) begin
      r = up ? cnt_t'(cur + 1'b1) : cnt_t'(cur - 1'b1);
    end else if (up) begin
      r = (cur >= cnt_t'(DEC_TOP)) ? '0 : cnt_t'(cur + 1'b1);
    end else begin
      r = (cur == '0 || cur > cnt_t'(DEC_TOP)) ? cnt_t'(DEC_TOP) : cnt_t'(cur - 1'b1);
    end
    return r;
  endfunction

  // Terminal count for the selected direction and modulus.
  function automatic logic at_terminal(input cnt_t cur, input logic up, input logic bin);
    logic t;
    if (!up)      t = (cur == '0);
    else if (bin) t = (cur == cnt_t'(BIN_TOP));
    else          t = (cur == cnt_t'(DEC_TOP));
    return t;
  endfunction

endpackage

// File: rtl/updown_cnt_next.sv
module updown_cnt_next
  import updown_cnt_pkg::*;
(
  input  cnt_t cur,
  input  logic up_sel,
  input  logic bin_sel,
  output cnt_t nxt,
  output logic term
);
  always_comb begin
    nxt  = step_value(cur, up_sel, bin_sel);
    term = at_terminal(cur, up_sel, bin_sel);
  end
endmodule

// File: rtl/updown_cnt_state.sv
module updown_cnt_state
  import updown_cnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  cnt_t jam,
  input  logic adv,
  input  cnt_t nxt,
  output cnt_t q_reg
);
  // Asynchronous load; release is assumed synchronous to clk.
  always_ff @(posedge clk or negedge rst_n or posedge load_en) begin
    if (!rst_n)       q_reg <= '0;
    else if (load_en) q_reg <= jam;
    else if (adv)     q_reg <= nxt;
  end
endmodule

// File: rtl/updown_cnt_carry.sv
module updown_cnt_carry (
  input  logic cin_n,
  input  logic term,
  output logic cout_n
);
  assign cout_n = ~(term & ~cin_n);
endmodule

// File: rtl/updown_decbin_counter.sv
module updown_decbin_counter
  import updown_cnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cin_n,
  input  logic             bin_sel,
  input  logic             up_sel,
  input  logic             load_en,
  input  logic [CNT_W-1:0] jam,
  output logic [CNT_W-1:0] q,
  output logic             cout_n
);
  cnt_t q_reg;
  cnt_t q_vis;
  cnt_t nxt;
  logic term;
  logic adv;

  assign adv   = ~cin_n & ~load_en;
  assign q_vis = load_en ? jam : q_reg;

  updown_cnt_next u_next (
    .cur     (q_vis),
    .up_sel  (up_sel),
    .bin_sel (bin_sel),
    .nxt     (nxt),
    .term    (term)
  );

  updown_cnt_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .jam     (jam),
    .adv     (adv),
    .nxt     (nxt),
    .q_reg   (q_reg)
  );

  updown_cnt_carry u_carry (
    .cin_n  (cin_n),
    .term   (term),
    .cout_n (cout_n)
  );

  assign q = q_vis;
endmodule

// File: rtl/updown_decbin_counter_chk.sv
module updown_decbin_counter_chk
  import updown_cnt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cin_n,
  input logic bin_sel,
  input logic up_sel,
  input logic load_en,
  input cnt_t jam,
  input cnt_t q,
  input logic cout_n,
  input logic term,
  input logic adv
);
  // R1
  a_r1_preset_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> q == jam);

  // R2
  a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_n && !load_en) |=> (load_en || $stable(q)));

  // R3
  a_r3_bin_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bin_sel && up_sel) |=> (load_en || q == cnt_t'($past(q) + 1'b1)));

  // R4
  a_r4_bin_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bin_sel && !up_sel) |=> (load_en || q == cnt_t'($past(q) - 1'b1)));

  // R5
  a_r5_dec_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !bin_sel && up_sel && q == cnt_t'(DEC_TOP)) |=> (load_en || q == '0));

  // R6
  a_r6_dec_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !bin_sel && !up_sel && q == '0) |=> (load_en || q == cnt_t'(DEC_TOP)));

  // R7
  a_r7_carry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cin_n |-> cout_n);
  a_r7_carry_from_term: assert property (@(posedge clk) disable iff (!rst_n)
    (!cin_n && term) |-> !cout_n);

  // R8
  a_r8_no_illegal_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!bin_sel && q > cnt_t'(DEC_TOP)) |-> cout_n);

  // R9
  always @(negedge clk) begin
    if (!rst_n && !load_en) begin
      a_r9_reset_clear: assert (q == '0);
    end
  end
endmodule

bind updown_decbin_counter updown_decbin_counter_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cin_n   (cin_n),
  .bin_sel (bin_sel),
  .up_sel  (up_sel),
  .load_en (load_en),
  .jam     (jam),
  .q       (q),
  .cout_n  (cout_n),
  .term    (term),
  .adv     (adv)
);

// File: tb/updown_decbin_counter_tb_top.sv
module updown_decbin_counter_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cin_n = 1'b1;
  logic bin_sel = 1'b1;
  logic up_sel = 1'b1;
  logic load_en = 1'b0;
  logic [3:0] jam = 4'd0;
  logic [3:0] q;
  logic cout_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updown_decbin_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cin_n(cin_n), .bin_sel(bin_sel), .up_sel(up_sel),
    .load_en(load_en), .jam(jam), .q(q), .cout_n(cout_n)
  );

  // Three-digit decade chain (R10)
  logic chain_load = 1'b0;
  logic [3:0] chain_jam [3];
  logic [3:0] cq [3];
  logic cco [3];
  logic ccin [3];

  for (genvar g = 0; g < 3; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign ccin[g] = 1'b0;
    end else begin : g_rest
      assign ccin[g] = cco[g-1];
    end
    updown_decbin_counter u_stage (
      .clk(clk), .rst_n(rst_n), .cin_n(ccin[g]), .bin_sel(1'b0), .up_sel(1'b1),
      .load_en(chain_load), .jam(chain_jam[g]), .q(cq[g]), .cout_n(cco[g])
    );
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // {jam[4], bin, up, cin_n, nclk[5], exp_q[4], exp_cout_n}
  localparam int NV = 15;
  localparam logic [16:0] VECS [NV] = '{
    {4'd3,  1'b1, 1'b1, 1'b0, 5'd2, 4'd5,  1'b1}, // R3 R11
    {4'd14, 1'b1, 1'b1, 1'b0, 5'd1, 4'd15, 1'b0}, // R3 R7
    {4'd14, 1'b1, 1'b1, 1'b0, 5'd2, 4'd0,  1'b1}, // R3 wrap
    {4'd1,  1'b1, 1'b0, 1'b0, 5'd1, 4'd0,  1'b0}, // R4 R7
    {4'd1,  1'b1, 1'b0, 1'b0, 5'd2, 4'd15, 1'b1}, // R4 wrap
    {4'd7,  1'b0, 1'b1, 1'b0, 5'd2, 4'd9,  1'b0}, // R5 R7
    {4'd8,  1'b0, 1'b1, 1'b0, 5'd3, 4'd1,  1'b1}, // R5 wrap
    {4'd1,  1'b0, 1'b0, 1'b0, 5'd3, 4'd8,  1'b1}, // R6 wrap
    {4'd2,  1'b0, 1'b0, 1'b0, 5'd2, 4'd0,  1'b0}, // R6 R7
    {4'd6,  1'b1, 1'b1, 1'b1, 5'd5, 4'd6,  1'b1}, // R2 hold
    {4'd12, 1'b0, 1'b1, 1'b0, 5'd1, 4'd0,  1'b1}, // R8 up recovery
    {4'd13, 1'b0, 1'b0, 1'b0, 5'd1, 4'd9,  1'b1}, // R8 down recovery
    {4'd15, 1'b0, 1'b1, 1'b0, 5'd0, 4'd15, 1'b1}, // R8 no carry on illegal
    {4'd0,  1'b1, 1'b1, 1'b0, 5'd0, 4'd0,  1'b1}, // R1 zero load
    {4'd9,  1'b1, 1'b1, 1'b0, 5'd0, 4'd9,  1'b1}  // R7 nine not terminal in binary
  };

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    chain_jam[0] = 4'd0; chain_jam[1] = 4'd0; chain_jam[2] = 4'd0;
    // Reset state (R9)
    repeat (3) @(negedge clk);
    #1;
    check(q == 4'd0, "R9 reset count", q, 0);
    check(cout_n == 1'b1, "R7 reset carry idle", cout_n, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VECS[i];
      @(negedge clk);
      jam = v[16:13]; bin_sel = v[12]; up_sel = v[11];
      cin_n = 1'b1; load_en = 1'b1;
      @(negedge clk);
      load_en = 1'b0; cin_n = v[10];
      for (int k = 0; k < int'(v[9:5]); k++) @(negedge clk);
      #1;
      if (q != v[4:1]) begin
        checks++; errors++;
        $display("FAIL table[%0d] R1-R8 q actual=%0d expected=%0d", i, q, v[4:1]);
      end else checks++;
      if (cout_n != v[0]) begin
        checks++; errors++;
        $display("FAIL table[%0d] R7 cout_n actual=%0d expected=%0d", i, cout_n, v[0]);
      end else checks++;
    end

    // R1: preset visible without a clock edge
    @(negedge clk);
    cin_n = 1'b1; bin_sel = 1'b1; up_sel = 1'b1;
    #1 jam = 4'd11; load_en = 1'b1;
    #1 check(q == 4'd11, "R1 async preset", q, 11);

    // R2: preset held high across edges with enable low blocks counting
    cin_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(q == 4'd11, "R2 preset inhibits counting", q, 11);
    load_en = 1'b0;
    @(negedge clk);
    #1 check(q == 4'd12, "R11 first count after release", q, 12);

    // R7: carry-in reaches carry-out combinationally
    cin_n = 1'b1; jam = 4'd15; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    #1 check(cout_n == 1'b1, "R7 carry idle with cin_n high", cout_n, 1);
    #1 cin_n = 1'b0;
    #1 check(cout_n == 1'b0, "R7 carry follows cin_n", cout_n, 0);
    #1 cin_n = 1'b1;
    #1 check(cout_n == 1'b1, "R7 carry releases with cin_n", cout_n, 1);

    // R9: asynchronous clear mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(q == 4'd0, "R9 async clear", q, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: three-digit chain from 995 across 999
    chain_jam[0] = 4'd5; chain_jam[1] = 4'd9; chain_jam[2] = 4'd9;
    @(negedge clk);
    chain_load = 1'b1;
    @(negedge clk);
    chain_load = 1'b0;
    begin
      int model;
      int got;
      model = 995;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        #1;
        model = (model + 1) % 1000;
        got = int'(cq[2]) * 100 + int'(cq[1]) * 10 + int'(cq[0]);
        check(got == model, "R10 chain value", got, model);
      end
    end

    finish_run();
  end

endmodule